// File: doc/BRIEF.md
# Masked Vector Lane Writeback Stage

This stage sits at the end of a vector execution pipe whose elements are 32 bits wide. On every accepted operation it takes a source vector, applies a fixed element-wise operation to each lane, and merges the per-lane results into a new 512-bit destination value. The merge is steered by a per-lane write mask, or by a flag that bypasses the mask. Lanes whose mask bit is clear either keep the old destination contents or are forced to zero, depending on the masking mode.

The operating width is chosen per operation as 128, 256 or 512 bits. Every destination bit above that width is cleared. When the operand came from memory and the broadcast flag is set, lane 0 of the source feeds every lane. A register source always uses its own lanes. The element operation is chosen by a parameter: pass-through, or sign inversion (the default). The stage has one output register that loads only when the valid strobe is high.

Top module: `vec_lane_wb`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dst_o` becomes all zeros at that edge, whatever the other inputs are.
- R2: `dst_o` loads at a rising edge only when `valid_i` is high. Otherwise it holds its value.
- R3: `vlen_i` sets the active lane count. Code 0 gives 4 lanes (128 bits), code 1 gives 8 lanes (256 bits), and codes 2 and 3 give 16 lanes (512 bits).
- R4: An active lane j whose mask bit `mask_i[j]` is 1, or any active lane when `nomask_i` is 1, receives the operation result. With the default parameter, the result is the selected source element with bit 31 inverted.
- R5: With `zeroing_i` = 0 (merging), an active lane that is not written takes the matching 32 bits of `old_dst_i`.
- R6: With `zeroing_i` = 1, an active lane that is not written becomes zero.
- R7: When `bcast_i` and `mem_src_i` are both 1, every lane operates on source bits [31:0]. Otherwise lane j operates on source bits [32j+31:32j].
- R8: `bcast_i` has no effect when `mem_src_i` is 0.
- R9: Every `dst_o` bit at or above 32 times the active lane count is zero after a load, for any mask and any mode.
- R10: Mask bits at positions at or above the active lane count have no effect on `dst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Load strobe for the output register |
| vlen_i | input | 2 | Vector length code (0: 128, 1: 256, 2 or 3: 512 bits) |
| mask_i | input | 16 | Per-lane write mask, bit j for lane j |
| nomask_i | input | 1 | Writes all active lanes and ignores the mask |
| zeroing_i | input | 1 | 1: unwritten lanes are zeroed; 0: they keep the old value |
| bcast_i | input | 1 | Broadcast source element 0 (memory sources only) |
| mem_src_i | input | 1 | Source operand came from memory |
| src_i | input | 512 | Source vector, 16 lanes of 32 bits |
| old_dst_i | input | 512 | Previous destination value |
| dst_o | output | 512 | Registered new destination value |

## Verification
The only state is the output register, so any wrong internal decision appears at `dst_o` one edge after the strobe that caused it. A bad lane count shows as nonzero bits above the active width, or as a missing result in an upper lane. A swapped mode shows as old data where zeros belong, or the reverse. A broadcast fault shows as lanes that differ although they should all carry a copy of lane 0. The bench runs every combination of length code, mask bypass, mode, broadcast and source kind with random masks and data. It also runs random sequences in which the strobe is sometimes low, to expose a register that loads when it should hold.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

    localparam int ELEM_W    = 32;
    localparam int MAX_LANES = 16;

    typedef enum logic [1:0] {
        VL_128     = 2'd0,
        VL_256     = 2'd1,
        VL_512     = 2'd2,
        VL_512_ALT = 2'd3
    } vlen_e;

    typedef enum logic {
        OP_PASS = 1'b0,
        OP_NEG  = 1'b1
    } op_e;

    typedef struct packed {
        vlen_e vlen;
        logic  nomask;
        logic  zeroing;
        logic  bcast;
        logic  mem_src;
    } wb_ctrl_t;

    // number of lanes enabled by a length code, for a datapath of 'total' lanes
    function automatic int unsigned active_lanes(vlen_e v, int unsigned total);
        case (v)
            VL_128:  return total / 4;
            VL_256:  return total / 2;
            default: return total;
        endcase
    endfunction

    // placeholder element operation
    function automatic logic [ELEM_W-1:0] lane_op(op_e k, logic [ELEM_W-1:0] x);
        logic [ELEM_W-1:0] sign_bit;
        sign_bit = '0;
        sign_bit[ELEM_W-1] = 1'b1;
        return (k == OP_NEG) ? (x ^ sign_bit) : x;
    endfunction

endpackage

// File: rtl/vlw_src_sel.sv
module vlw_src_sel
    import vlw_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    localparam int DW   = LANES * ELEM_W
) (
    input  logic          bcast_en,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] operand
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign operand[j*ELEM_W +: ELEM_W] =
            bcast_en ? src[ELEM_W-1:0] : src[j*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/vlw_lane_op.sv
module vlw_lane_op
    import vlw_pkg::*;
#(
    parameter op_e OP = OP_NEG
) (
    input  logic [ELEM_W-1:0] a,
    output logic [ELEM_W-1:0] y
);

    assign y = lane_op(OP, a);

endmodule

// File: rtl/vlw_merge.sv
module vlw_merge
    import vlw_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    localparam int DW   = LANES * ELEM_W,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic [DW-1:0]    result,
    input  logic [DW-1:0]    old_dst,
    input  logic [LANES-1:0] mask,
    input  logic             nomask,
    input  logic             zeroing,
    input  logic [CW-1:0]    n_active,
    output logic [DW-1:0]    merged
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic lane_on;
        logic lane_wr;
        assign lane_on = (CW'(j) < n_active);
        assign lane_wr = nomask | mask[j];

        always_comb begin
            if (!lane_on)
                merged[j*ELEM_W +: ELEM_W] = '0;
            else if (lane_wr)
                merged[j*ELEM_W +: ELEM_W] = result[j*ELEM_W +: ELEM_W];
            else if (zeroing)
                merged[j*ELEM_W +: ELEM_W] = '0;
            else
                merged[j*ELEM_W +: ELEM_W] = old_dst[j*ELEM_W +: ELEM_W];
        end
    end

endmodule

// File: rtl/vec_lane_wb.sv
module vec_lane_wb
    import vlw_pkg::*;
#(
    parameter int  LANES = MAX_LANES,
    parameter op_e OP    = OP_NEG,
    localparam int DW    = LANES * ELEM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [1:0]       vlen_i,
    input  logic [LANES-1:0] mask_i,
    input  logic             nomask_i,
    input  logic             zeroing_i,
    input  logic             bcast_i,
    input  logic             mem_src_i,
    input  logic [DW-1:0]    src_i,
    input  logic [DW-1:0]    old_dst_i,
    output logic [DW-1:0]    dst_o
);

    localparam int CW = $clog2(LANES + 1);

    wb_ctrl_t      ctrl;
    logic [CW-1:0] n_act;
    logic [DW-1:0] operand;
    logic [DW-1:0] result;
    logic [DW-1:0] merged;

    assign ctrl.vlen    = vlen_e'(vlen_i);
    assign ctrl.nomask  = nomask_i;
    assign ctrl.zeroing = zeroing_i;
    assign ctrl.bcast   = bcast_i;
    assign ctrl.mem_src = mem_src_i;

    assign n_act = CW'(active_lanes(ctrl.vlen, LANES));

    vlw_src_sel #(.LANES(LANES)) u_sel (
        .bcast_en (ctrl.bcast & ctrl.mem_src),
        .src      (src_i),
        .operand  (operand)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_op
        vlw_lane_op #(.OP(OP)) u_op (
            .a (operand[j*ELEM_W +: ELEM_W]),
            .y (result[j*ELEM_W +: ELEM_W])
        );
    end

    vlw_merge #(.LANES(LANES)) u_merge (
        .result   (result),
        .old_dst  (old_dst_i),
        .mask     (mask_i),
        .nomask   (ctrl.nomask),
        .zeroing  (ctrl.zeroing),
        .n_active (n_act),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dst_o <= '0;
        else if (valid_i)
            dst_o <= merged;
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> dst_o == '0);

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(dst_o));

    a_r9_upper_zero_128: assert property (@(posedge clk) disable iff (rst)
        valid_i && vlen_i == 2'd0 |=> dst_o[DW-1:DW/4] == '0);

    a_r3_upper_zero_256: assert property (@(posedge clk) disable iff (rst)
        valid_i && vlen_i == 2'd1 |=> dst_o[DW-1:DW/2] == '0);

    a_r4_nomask_lane0: assert property (@(posedge clk) disable iff (rst)
        valid_i && nomask_i |=> dst_o[ELEM_W-1:0] == lane_op(OP, $past(src_i[ELEM_W-1:0])));

    a_r5_merge_keeps_old: assert property (@(posedge clk) disable iff (rst)
        valid_i && !nomask_i && !mask_i[0] && !zeroing_i
        |=> dst_o[ELEM_W-1:0] == $past(old_dst_i[ELEM_W-1:0]));

    a_r6_zeroing_clears: assert property (@(posedge clk) disable iff (rst)
        valid_i && !nomask_i && !mask_i[0] && zeroing_i |=> dst_o[ELEM_W-1:0] == '0);

    a_r7_broadcast_lane1: assert property (@(posedge clk) disable iff (rst)
        valid_i && nomask_i && bcast_i && mem_src_i
        |=> dst_o[2*ELEM_W-1:ELEM_W] == lane_op(OP, $past(src_i[ELEM_W-1:0])));

    a_r8_reg_src_lane1: assert property (@(posedge clk) disable iff (rst)
        valid_i && nomask_i && !mem_src_i
        |=> dst_o[2*ELEM_W-1:ELEM_W] == lane_op(OP, $past(src_i[2*ELEM_W-1:ELEM_W])));

endmodule

// File: tb/vec_lane_wb_test.sv
module vec_lane_wb_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [1:0]   vlen_i = '0;
    logic [15:0]  mask_i = '0;
    logic         nomask_i = 1'b0;
    logic         zeroing_i = 1'b0;
    logic         bcast_i = 1'b0;
    logic         mem_src_i = 1'b0;
    logic [511:0] src_i = '0;
    logic [511:0] old_dst_i = '0;
    logic [511:0] dst_o;

    int checks = 0;
    int fails  = 0;
    logic [511:0] last_exp = '0;

    always #10 clk = ~clk;

    vec_lane_wb uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .vlen_i(vlen_i), .mask_i(mask_i),
        .nomask_i(nomask_i), .zeroing_i(zeroing_i), .bcast_i(bcast_i),
        .mem_src_i(mem_src_i), .src_i(src_i), .old_dst_i(old_dst_i), .dst_o(dst_o)
    );

    function automatic logic [511:0] rand512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // expected destination, written from the requirements
    function automatic logic [511:0] model(logic [1:0] vl, logic [15:0] m, logic nm, logic zm,
                                           logic bc, logic ms, logic [511:0] s, logic [511:0] o);
        logic [511:0] r;
        int n;
        logic [31:0] e;
        n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        r = '0;
        for (int j = 0; j < 16; j++) begin
            if (j < n) begin
                e = (bc && ms) ? s[31:0] : s[j*32 +: 32];
                if (nm || m[j]) r[j*32 +: 32] = e ^ 32'h8000_0000;
                else if (zm)    r[j*32 +: 32] = 32'h0;
                else            r[j*32 +: 32] = o[j*32 +: 32];
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [511:0] got, logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // drive at negedge, check one edge later at the next negedge
    task automatic op(string tag, logic v, logic [1:0] vl, logic [15:0] m, logic nm, logic zm,
                      logic bc, logic ms, logic [511:0] s, logic [511:0] o);
        valid_i = v; vlen_i = vl; mask_i = m; nomask_i = nm; zeroing_i = zm;
        bcast_i = bc; mem_src_i = ms; src_i = s; old_dst_i = o;
        if (v) last_exp = model(vl, m, nm, zm, bc, ms, s, o);
        @(negedge clk);
        check(tag, dst_o, last_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [511:0] s, o, r_a, r_b;
        string tg;
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: strobe high during reset still yields zero
        valid_i = 1'b1; nomask_i = 1'b1; src_i = rand512(); vlen_i = 2'd2;
        @(negedge clk);
        check("R1 reset", dst_o, '0);
        rst = 1'b0;
        valid_i = 1'b0;
        @(negedge clk);
        check("R1 after release", dst_o, '0);

        // R4 concrete: +1.0 in lane 0 becomes -1.0
        s = '0; s[31:0] = 32'h3F80_0000;
        op("R4 sign flip", 1, 2'd2, 16'h0000, 1, 0, 0, 0, s, '0);
        check("R4 lane0 value", {480'd0, dst_o[31:0]}, {480'd0, 32'hBF80_0000});

        // sweep all mode combinations
        for (int vl = 0; vl < 4; vl++)
            for (int c = 0; c < 16; c++) begin
                tg = (c[1] && c[0]) ? "R7" : c[1] ? "R8" : c[3] ? "R4" : c[2] ? "R6" : "R5";
                tg = {tg, (vl < 2) ? " R9" : " R3"};
                op(tg, 1, 2'(vl), 16'($urandom), c[3], c[2], c[1], c[0], rand512(), rand512());
            end

        // R7 directed: distinct lanes, broadcast from memory
        s = rand512(); o = rand512();
        op("R7 broadcast", 1, 2'd2, 16'hA5A5, 0, 0, 1, 1, s, o);
        // R8 directed: same with register source
        op("R8 reg source", 1, 2'd2, 16'hFFFF, 0, 0, 1, 0, s, o);
        // R3: code 3 behaves as full width
        op("R3 code3", 1, 2'd3, 16'hFFFF, 0, 0, 0, 0, s, o);
        check("R3 code3 top lane", {480'd0, dst_o[511:480]}, {480'd0, s[511:480] ^ 32'h8000_0000});
        // R10: upper mask bits set, 128-bit width, merging
        op("R10 upper mask merge", 1, 2'd0, 16'hFFF0, 0, 0, 0, 0, s, o);
        // R10: two masks differing only above the lane count give equal results
        op("R10 mask a", 1, 2'd1, 16'hFF00, 0, 1, 0, 0, s, o);
        r_a = dst_o;
        op("R10 mask b", 1, 2'd1, 16'h0000, 0, 1, 0, 0, s, o);
        r_b = dst_o;
        check("R10 mask independence", r_a, r_b);
        // R9: every upper bit zero with nomask, 256-bit
        op("R9 upper zero", 1, 2'd1, 16'hFFFF, 1, 0, 0, 0, s, o);
        // R2: strobe low keeps the last loaded value
        op("R2 hold", 0, 2'd2, 16'hFFFF, 1, 0, 0, 0, rand512(), rand512());

        // random sequence with occasional idle cycles
        for (int k = 0; k < 400; k++) begin
            logic v;
            v = ($urandom % 4) != 0;
            op(v ? "R4 R5 R6 R7 random" : "R2 random hold", v, 2'($urandom), 16'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rand512(), rand512());
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule